// File: doc/BRIEF.md
# Serial Digit Loader with Handshake

This block loads a bank of seven-segment digit latches one digit at a time over a four-wire serial link. A host drives a data line and a data clock, then strobes a write line. The block answers on an active-low accept line. Each word holds up to ten bits: two annunciator flags, a four-bit character code and a four-bit digit address. The word is shifted in on rising data-clock edges. Once the character code and the address are complete, the accept line goes low. A write strobe in that state turns the character code into a segment pattern and stores it, together with the annunciator flags, in the addressed digit's 9-bit latch. A write strobe at any other time only clears the serial interface, so the host can use it to resynchronise before each word.

The shift register is right-aligned and zero-filled. A host may therefore leave out the leading annunciator bits, sending eight bits for a bare character or nine bits for a character with the second annunciator. A word that runs past ten bits is discarded. A word whose address points past the last digit is dropped when it is committed. The serial inputs are asynchronous to the system clock: they are synchronised and edge-detected before the block acts on them.

Top module: `serial_digit_loader`

## Requirements
- R1: While `rst` is high, and after it is released, every digit latch reads zero and `accept_n` is high.
- R2: One bit of `ser_data` is taken on each rising edge of `ser_clk`. The first bit of a full ten-bit word is AN1, then AN2, then code bits C0..C3 (C0 least significant), then address bits A0..A3 (A3 last).
- R3: `accept_n` stays high while fewer than 8 bits are held and goes low when the 8th bit arrives.
- R4: A rising edge of `wr_strobe` while `accept_n` is low stores the word into digit A3..A0 (binary 0 to 9). Digit k appears at `digits_o[9k+8:9k]`, with bit 8 = AN1, bit 7 = AN2 and bits 6:0 = segment pattern.
- R5: Segment bits 6:0 are g,f,e,d,c,b,a. Codes 0..F give the hex patterns 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R6: When only 8 bits are sent, both annunciators are stored as 0. When 9 bits are sent, the first bit is AN2 and AN1 is stored as 0.
- R7: A rising edge of `wr_strobe` while `accept_n` is high changes no latch. It clears the partial word, so the next bit sent is taken as the first bit of a new word.
- R8: After a committing write strobe, `accept_n` returns high.
- R9: An eleventh `ser_clk` rising edge discards the word and sets `accept_n` high. A following write strobe changes no latch.
- R10: A committing write strobe with address 10..15 changes no latch.
- R11: A commit changes only the addressed digit, and no latch changes without a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data bit, asynchronous |
| ser_clk | input | 1 | Serial data clock, rising edge shifts, asynchronous |
| wr_strobe | input | 1 | Write strobe, rising edge commits or clears, asynchronous |
| accept_n | output | 1 | Low when a word of at least 8 bits is held |
| digits_o | output | NUM_DIGITS*9 | All digit latches, digit k at bits 9k+8:9k |

## Verification
A bit counter that is off by one shows as `accept_n` falling one data-clock edge early or late, about three system clocks after that edge. It also shows as a commit where every field lands one position off. A wrong alignment of the shift register shows in the stored latch of the next commit, as swapped annunciators or a wrong character or address. An overrun or range check that lets a word through shows as a changed latch about four clocks after the write strobe, while all other digits are compared as well.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int ANN_W   = 2;
  localparam int CODE_W  = 4;
  localparam int ADDR_W  = 4;
  localparam int SEG_W   = 7;
  localparam int WORD_W  = ANN_W + CODE_W + ADDR_W;
  localparam int MIN_BITS = CODE_W + ADDR_W;
  localparam int LATCH_W = ANN_W + SEG_W;

  // segment order g,f,e,d,c,b,a (bit 6 down to bit 0)
  function automatic logic [SEG_W-1:0] hex_font(input logic [CODE_W-1:0] code);
    case (code)
      4'h0: hex_font = 7'h3F;
      4'h1: hex_font = 7'h06;
      4'h2: hex_font = 7'h5B;
      4'h3: hex_font = 7'h4F;
      4'h4: hex_font = 7'h66;
      4'h5: hex_font = 7'h6D;
      4'h6: hex_font = 7'h7D;
      4'h7: hex_font = 7'h07;
      4'h8: hex_font = 7'h7F;
      4'h9: hex_font = 7'h6F;
      4'hA: hex_font = 7'h77;
      4'hB: hex_font = 7'h7C;
      4'hC: hex_font = 7'h39;
      4'hD: hex_font = 7'h5E;
      4'hE: hex_font = 7'h79;
      default: hex_font = 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/sdl_sync_edge.sv
module sdl_sync_edge #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int DEPTH = STAGES + (EDGE ? 1 : 0);

  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[DEPTH-2:0], din};
  end

  generate
    if (EDGE) begin : g_rise
      assign dout = pipe[STAGES-1] & ~pipe[STAGES];
    end else begin : g_level
      assign dout = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sdl_shift_ctrl.sv
module sdl_shift_ctrl
  import sdl_pkg::*;
#(
  parameter int NUM_DIGITS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_in,
  input  logic               clk_rise,
  input  logic               wr_rise,
  output logic               accept_n,
  output logic               we,
  output logic [ADDR_W-1:0]  waddr,
  output logic [LATCH_W-1:0] wdata
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_now;
  logic [CODE_W-1:0] code_now;

  // first-sent bit of each field is its least significant bit
  always_comb begin
    for (int i = 0; i < ADDR_W; i++) addr_now[i] = sr[ADDR_W-1-i];
    for (int i = 0; i < CODE_W; i++) code_now[i] = sr[ADDR_W+CODE_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      cnt      <= '0;
      accept_n <= 1'b1;
      we       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (wr_rise) begin
        if (int'(cnt) >= MIN_BITS && int'(addr_now) < NUM_DIGITS) begin
          we    <= 1'b1;
          waddr <= addr_now;
          wdata <= {sr[WORD_W-1:MIN_BITS], hex_font(code_now)};
        end
        sr       <= '0;
        cnt      <= '0;
        accept_n <= 1'b1;
      end else if (clk_rise) begin
        if (int'(cnt) == WORD_W) begin
          sr       <= '0;
          cnt      <= '0;
          accept_n <= 1'b1;
        end else begin
          sr       <= {sr[WORD_W-2:0], bit_in};
          cnt      <= cnt + 1'b1;
          accept_n <= !(int'(cnt) + 1 >= MIN_BITS);
        end
      end
    end
  end

  // R3
  accept_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(accept_n) |-> $past(clk_rise));

  // R8, R9
  accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_n) |-> $past(wr_rise || clk_rise));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= WORD_W);
endmodule

// File: rtl/sdl_digit_bank.sv
module sdl_digit_bank
  import sdl_pkg::*;
#(
  parameter int NUM_DIGITS = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [LATCH_W-1:0]            wdata,
  output logic [NUM_DIGITS*LATCH_W-1:0] digits_o
);
  logic [LATCH_W-1:0] mem [NUM_DIGITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_DIGITS; k++) mem[k] <= '0;
    end else if (we && int'(waddr) < NUM_DIGITS) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_out
      assign digits_o[k*LATCH_W +: LATCH_W] = mem[k];
    end
  endgenerate

  // R10
  we_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> int'(waddr) < NUM_DIGITS);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(digits_o));
endmodule

// File: rtl/serial_digit_loader.sv
module serial_digit_loader
  import sdl_pkg::*;
#(
  parameter int NUM_DIGITS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ser_data,
  input  logic                          ser_clk,
  input  logic                          wr_strobe,
  output logic                          accept_n,
  output logic [NUM_DIGITS*LATCH_W-1:0] digits_o
);
  localparam int N_IN = 3;
  localparam logic [N_IN-1:0] IS_EDGE = 3'b011;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] sync_out;
  logic            we;
  logic [ADDR_W-1:0]  waddr;
  logic [LATCH_W-1:0] wdata;

  assign raw_in = {ser_data, ser_clk, wr_strobe};

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_sync
      sdl_sync_edge #(.STAGES(SYNC_STAGES), .EDGE(IS_EDGE[i])) sync_i (
        .clk (clk),
        .rst (rst),
        .din (raw_in[i]),
        .dout(sync_out[i])
      );
    end
  endgenerate

  sdl_shift_ctrl #(.NUM_DIGITS(NUM_DIGITS)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (sync_out[2]),
    .clk_rise(sync_out[1]),
    .wr_rise (sync_out[0]),
    .accept_n(accept_n),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata)
  );

  sdl_digit_bank #(.NUM_DIGITS(NUM_DIGITS)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .digits_o(digits_o)
  );
endmodule

// File: tb/serial_digit_loader_tb_top.sv
module serial_digit_loader_tb_top;
  localparam int ND = 10;
  localparam int LW = 9;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0;
  logic ser_clk = 1'b0;
  logic wr_strobe = 1'b0;
  logic accept_n;
  logic [ND*LW-1:0] digits_o;
  logic [ND*LW-1:0] model = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_digit_loader #(.NUM_DIGITS(ND), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .wr_strobe(wr_strobe), .accept_n(accept_n), .digits_o(digits_o)
  );

  // {nbits, an1, an2, code, addr}
  localparam logic [13:0] VEC [NV] = '{
    {4'd10, 1'b1, 1'b1, 4'h0, 4'd0},
    {4'd10, 1'b0, 1'b1, 4'h1, 4'd1},
    {4'd10, 1'b1, 1'b0, 4'h2, 4'd2},
    {4'd9,  1'b1, 1'b1, 4'h3, 4'd3},
    {4'd8,  1'b1, 1'b1, 4'h4, 4'd4},
    {4'd10, 1'b1, 1'b1, 4'h5, 4'd5},
    {4'd10, 1'b0, 1'b0, 4'h6, 4'd6},
    {4'd9,  1'b0, 1'b1, 4'h7, 4'd7},
    {4'd8,  1'b0, 1'b0, 4'hB, 4'd8},
    {4'd10, 1'b1, 1'b1, 4'hD, 4'd9},
    {4'd10, 1'b1, 1'b1, 4'hA, 4'd10},
    {4'd10, 1'b0, 1'b1, 4'hF, 4'd15},
    {4'd10, 1'b0, 1'b0, 4'hE, 4'd0},
    {4'd9,  1'b1, 1'b0, 4'hC, 4'd9}
  };

  function automatic logic [6:0] font(input logic [3:0] c);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[c];
  endfunction

  task automatic chk(input string tag, input logic [ND*LW-1:0] got, input logic [ND*LW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    cyc(4);
    ser_clk = 1'b1;
    cyc(6);
    ser_clk = 1'b0;
    cyc(4);
  endtask

  task automatic strobe();
    wr_strobe = 1'b1;
    cyc(6);
    wr_strobe = 1'b0;
    cyc(6);
  endtask

  task automatic send_word(input int nb, input logic a1, input logic a2,
                           input logic [3:0] c, input logic [3:0] a);
    logic [9:0] seq;
    seq = {a1, a2, c[0], c[1], c[2], c[3], a[0], a[1], a[2], a[3]};
    for (int i = 10 - nb; i < 10; i++) send_bit(seq[9-i]);
  endtask

  task automatic model_put(input int nb, input logic a1, input logic a2,
                           input logic [3:0] c, input logic [3:0] a);
    if (a < 4'd10)
      model[a*LW +: LW] = {(nb == 10) ? a1 : 1'b0, (nb >= 9) ? a2 : 1'b0, font(c)};
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(5);
    // R1 during reset
    chk("R1 reset digits", digits_o, '0);
    chk("R1 reset accept_n", {89'b0, accept_n}, 90'd1);
    rst = 1'b0;
    cyc(4);
    chk("R1 after release", digits_o, '0);

    // R2 bit order with an asymmetric word
    strobe();
    send_word(10, 1'b1, 1'b0, 4'h1, 4'd3);
    strobe();
    model_put(10, 1'b1, 1'b0, 4'h1, 4'd3);
    chk("R2 bit order", digits_o, model);

    // R3 threshold
    strobe();
    send_word(7, 1'b0, 1'b0, 4'h0, 4'h0);
    chk("R3 7 bits accept_n", {89'b0, accept_n}, 90'd1);
    send_bit(1'b0);
    chk("R3 8 bits accept_n", {89'b0, accept_n}, 90'd0);
    strobe();

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [3:0] nb;
      logic a1, a2;
      logic [3:0] c, a;
      string tag;
      {nb, a1, a2, c, a} = VEC[v];
      send_word(int'(nb), a1, a2, c, a);
      chk("R3 ready before write", {89'b0, accept_n}, 90'd0);
      strobe();
      chk("R8 accept_n after write", {89'b0, accept_n}, 90'd1);
      model_put(int'(nb), a1, a2, c, a);
      // R5 patterns, R11 other digits
      tag = (a >= 4'd10) ? "R10 range" : (nb < 4'd10) ? "R6 short word" : "R4 commit";
      chk(tag, digits_o, model);
    end

    // R7 partial word then write: no change, realign
    send_word(5, 1'b1, 1'b1, 4'h9, 4'd9);
    strobe();
    chk("R7 no change", digits_o, model);
    send_word(10, 1'b0, 1'b1, 4'h8, 4'd2);
    chk("R7 realigned ready", {89'b0, accept_n}, 90'd0);
    strobe();
    model_put(10, 1'b0, 1'b1, 4'h8, 4'd2);
    chk("R7 realigned commit", digits_o, model);

    // R9 overrun
    send_word(10, 1'b1, 1'b1, 4'h2, 4'd1);
    send_bit(1'b1);
    chk("R9 accept_n after 11th", {89'b0, accept_n}, 90'd1);
    strobe();
    chk("R9 no change", digits_o, model);

    // R1 mid-run reset
    send_word(9, 1'b0, 1'b1, 4'h3, 4'd4);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(3);
    chk("R1 mid reset digits", digits_o, '0);
    chk("R1 mid reset accept_n", {89'b0, accept_n}, 90'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule